// File: doc/BRIEF.md
# Three-Wire Tuner Register Loader

This block is the serial front end of a tuner synthesizer. A host writes it over three lines: an enable, a bus clock and a data line. While enable is high, the block takes in one data bit on every falling edge of the bus clock. It counts the rising edges, and it also counts the bits taken in. The length of the frame then decides which internal registers are updated, and in which cycle.

There are three destinations:
- a 4-bit band-switch register;
- a 15-bit divider register;
- a control group holding three test bits, a charge-pump current select, a reference-ratio select and an oscillator-select bit.

A second ratio-select bit (the "A" ratio bit) is driven only by the length of short frames. A tuning-enable output stays low from reset until the first divider value arrives.

The bus lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the edges are found in the system clock domain. The block therefore expects the bus to run several times slower than the system clock.

Top module: `tuner_serial_loader`

## Requirements
- R1: While `rst_n` is low, the outputs are set to these values: band 0000, divider 0, test bits 001, charge-pump select 1 (high current), ratio-B 1, oscillator-select 0, ratio-A 1, tuning-enable 0.
- R2: A data bit is taken only on a falling bus-clock edge while enable is high. Bits arrive most significant first. Clock edges while enable is low change nothing.
- R3: On the 5th rising bus-clock edge of a frame, the band register takes the first four bits received. A frame with fewer than five rising edges leaves the band register as it was.
- R4: At the fall of enable after exactly 19 bits, the divider takes bits 5..19 (N14..N0) and ratio-A is cleared to 0.
- R5: At the fall of enable after exactly 18 bits, the divider takes {0, bits 5..18} and ratio-A is set to 1.
- R6: In a 27-bit frame, the divider is written on the 20th rising bus-clock edge, while enable is still high. Bits 20..27 are {T2, T1, T0, charge-pump, ratio-B, oscillator-select, reserved, reserved}, and they are written to the control group at the fall of enable.
- R7: Frames of 18 or 19 bits leave the control group unchanged. A 27-bit frame leaves ratio-A unchanged.
- R8: A frame of fewer than 18 bits leaves the divider and ratio-A unchanged.
- R9: A frame of 20 to 26 bits, or of more than 27 bits, keeps the divider written on the 20th rising edge and changes neither the control group nor ratio-A.
- R10: Tuning-enable rises with the first divider write and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en_i | input | 1 | Serial enable line (frame active while high) |
| bus_clk_i | input | 1 | Serial bus clock |
| bus_dat_i | input | 1 | Serial data line |
| band_o | output | 4 | Band-switch register |
| divider_o | output | 15 | Divider register |
| test_o | output | 3 | Test bits T2..T0 |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| rsb_o | output | 1 | Reference ratio-B select |
| os_o | output | 1 | Oscillator-select bit |
| rsa_o | output | 1 | Reference ratio-A select |
| tune_en_o | output | 1 | Tuning output enable |

## Verification
The bound checker watches several properties on every cycle:
- the band, divider and control outputs change only in the cycle after their own write strobe;
- a short-frame write always leaves divider bit 14 clear with ratio-A set;
- a 19-bit write always leaves ratio-A clear;
- tuning-enable never falls outside reset;
- the values applied in reset are correct.

Only the bench scenarios can show that the strobes fire at the right bit count and rising-edge count, and that bits land in the right fields in most-significant-first order. They also show that clock pulses with enable low are ignored, that the divider is already written before enable falls in a long frame, and that illegal lengths keep only the edge-count writes.

// File: rtl/tsl_pkg.sv
// Shared widths, frame lengths and reset values for the three-wire loader.
// Assumes frame layout: band bits, then divider bits, then control byte.
package tsl_pkg;
    localparam int BAND_W    = 4;
    localparam int DIV_W     = 15;
    localparam int CTRL_W    = 8;
    localparam int TEST_W    = 3;
    localparam int LEN_SHORT = BAND_W + DIV_W - 1;
    localparam int LEN_LONG  = BAND_W + DIV_W;
    localparam int LEN_FULL  = LEN_LONG + CTRL_W;
    localparam int CNT_W     = $clog2(LEN_FULL + 1) + 1;

    typedef struct packed {
        logic [TEST_W-1:0] test;
        logic              cp_hi;
        logic              rsb;
        logic              os;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{test: 3'b001, cp_hi: 1'b1, rsb: 1'b1, os: 1'b0};
endpackage

// File: rtl/tsl_bus_sync.sv
// Multi-stage synchronizer for a group of asynchronous single-bit lines.
// Assumes each line is sampled independently; lines must be stable for
// several system clocks around the edges that matter.
module tsl_bus_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] pipe;

        // Shift the raw line through the synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[STAGES-2:0], async_i[g]};
            end
        end

        assign sync_o[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/tsl_edge_detect.sv
// Finds enable and bus-clock edges in the system clock domain.
// Assumes synchronized inputs; clock edges are reported only while enable is high.
module tsl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic sck_s,
    output logic en_rise,
    output logic en_fall,
    output logic sck_rise,
    output logic sck_fall
);
    logic en_q;
    logic sck_q;

    // Keep one cycle of history for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            en_q  <= en_s;
            sck_q <= sck_s;
        end
    end

    // Edge pulses, bus-clock edges gated by the enable level.
    always_comb begin
        en_rise  = en_s & ~en_q;
        en_fall  = ~en_s & en_q;
        sck_rise = en_s & sck_s & ~sck_q;
        sck_fall = en_s & ~sck_s & sck_q;
    end
endmodule

// File: rtl/tsl_frame_shifter.sv
// Shifts serial data in and counts the bits and rising edges of a frame.
// Issues one-cycle write strobes: band on rise BAND_W+1, early divider on
// rise LEN_LONG+1, and length-qualified strobes at the fall of enable.
// Assumes the counters restart on each rising edge of enable.
module tsl_frame_shifter
    import tsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_rise,
    input  logic             en_fall,
    input  logic             sck_rise,
    input  logic             sck_fall,
    input  logic             sdi,
    output logic [DIV_W-1:0] shreg,
    output logic             band_we,
    output logic             div_early_we,
    output logic             commit_short,
    output logic             commit_long,
    output logic             commit_full
);
    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] BAND_RISE = CNT_W'(BAND_W);
    localparam logic [CNT_W-1:0] DIV_RISE  = CNT_W'(LEN_LONG);
    localparam logic [CNT_W-1:0] N_SHORT   = CNT_W'(LEN_SHORT);
    localparam logic [CNT_W-1:0] N_LONG    = CNT_W'(LEN_LONG);
    localparam logic [CNT_W-1:0] N_FULL    = CNT_W'(LEN_FULL);

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] rise_cnt;

    // Shift data on falling edges; saturating bit and rise counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            rise_cnt <= '0;
        end else begin
            if (sck_fall) begin
                shreg <= {shreg[DIV_W-2:0], sdi};
                if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (sck_rise && rise_cnt != CNT_MAX) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            if (en_rise) begin
                bit_cnt  <= '0;
                rise_cnt <= sck_rise ? CNT_W'(1) : '0;
            end
        end
    end

    // Strobes from the edge counts and from the length at enable fall.
    always_comb begin
        band_we      = sck_rise && !en_rise && (rise_cnt == BAND_RISE);
        div_early_we = sck_rise && !en_rise && (rise_cnt == DIV_RISE);
        commit_short = en_fall && (bit_cnt == N_SHORT);
        commit_long  = en_fall && (bit_cnt == N_LONG);
        commit_full  = en_fall && (bit_cnt == N_FULL);
    end
endmodule

// File: rtl/tsl_commit_regs.sv
// Holds the band, divider, control, ratio-A and tuning-enable registers and
// applies the strobes from the shifter. Assumes at most one strobe per cycle.
module tsl_commit_regs
    import tsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  shreg,
    input  logic              band_we,
    input  logic              div_early_we,
    input  logic              commit_short,
    input  logic              commit_long,
    input  logic              commit_full,
    output logic [BAND_W-1:0] band,
    output logic [DIV_W-1:0]  divider,
    output ctrl_t             ctrl,
    output logic              rsa,
    output logic              tune_en
);
    ctrl_t ctrl_next;
    logic  unused_rsvd;

    // Decode the trailing control byte: T2 T1 T0 CP RSB OS, then reserved bits.
    always_comb begin
        ctrl_next.test  = shreg[CTRL_W-1 -: TEST_W];
        ctrl_next.cp_hi = shreg[CTRL_W-TEST_W-1];
        ctrl_next.rsb   = shreg[CTRL_W-TEST_W-2];
        ctrl_next.os    = shreg[CTRL_W-TEST_W-3];
        unused_rsvd     = ^shreg[CTRL_W-TEST_W-4:0];
    end

    // Band register: takes the first four bits on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band <= '0;
        end else if (band_we) begin
            band <= shreg[BAND_W-1:0];
        end
    end

    // Divider and ratio-A: early write, 19-bit write or 18-bit write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divider <= '0;
            rsa     <= 1'b1;
        end else if (div_early_we) begin
            divider <= shreg;
        end else if (commit_long) begin
            divider <= shreg;
            rsa     <= 1'b0;
        end else if (commit_short) begin
            divider <= {1'b0, shreg[DIV_W-2:0]};
            rsa     <= 1'b1;
        end
    end

    // Control group: written only by a full-length frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RESET;
        end else if (commit_full) begin
            ctrl <= ctrl_next;
        end
    end

    // Tuning enable: set on the first divider write, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tune_en <= 1'b0;
        end else if (div_early_we || commit_long || commit_short) begin
            tune_en <= 1'b1;
        end
    end
endmodule

// File: rtl/tuner_serial_loader.sv
// Top of the three-wire tuner register loader: synchronizer, edge detector,
// frame shifter and register bank. Assumes the bus runs well below clk.
module tuner_serial_loader
    import tsl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en_i,
    input  logic              bus_clk_i,
    input  logic              bus_dat_i,
    output logic [BAND_W-1:0] band_o,
    output logic [DIV_W-1:0]  divider_o,
    output logic [TEST_W-1:0] test_o,
    output logic              cp_hi_o,
    output logic              rsb_o,
    output logic              os_o,
    output logic              rsa_o,
    output logic              tune_en_o
);
    logic [2:0]       sync_lines;
    logic             en_rise, en_fall, sck_rise, sck_fall;
    logic [DIV_W-1:0] shreg;
    logic             band_we, div_early_we;
    logic             commit_short, commit_long, commit_full;
    logic             div_we;
    ctrl_t            ctrl;

    tsl_bus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_en_i, bus_clk_i, bus_dat_i}),
        .sync_o  (sync_lines)
    );

    tsl_edge_detect edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_s     (sync_lines[2]),
        .sck_s    (sync_lines[1]),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    tsl_frame_shifter shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_rise      (en_rise),
        .en_fall      (en_fall),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .sdi          (sync_lines[0]),
        .shreg        (shreg),
        .band_we      (band_we),
        .div_early_we (div_early_we),
        .commit_short (commit_short),
        .commit_long  (commit_long),
        .commit_full  (commit_full)
    );

    tsl_commit_regs regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .shreg        (shreg),
        .band_we      (band_we),
        .div_early_we (div_early_we),
        .commit_short (commit_short),
        .commit_long  (commit_long),
        .commit_full  (commit_full),
        .band         (band_o),
        .divider      (divider_o),
        .ctrl         (ctrl),
        .rsa          (rsa_o),
        .tune_en      (tune_en_o)
    );

    // Any divider write, for the bound checker.
    assign div_we = div_early_we | commit_long | commit_short;

    assign test_o  = ctrl.test;
    assign cp_hi_o = ctrl.cp_hi;
    assign rsb_o   = ctrl.rsb;
    assign os_o    = ctrl.os;
endmodule

// File: rtl/tsl_checker.sv
// Cycle-level properties of the loader, bound to the top module.
module tsl_checker
    import tsl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BAND_W-1:0] band,
    input logic [DIV_W-1:0]  divider,
    input logic [TEST_W-1:0] test,
    input logic              cp_hi,
    input logic              rsb,
    input logic              os,
    input logic              rsa,
    input logic              tune_en,
    input logic              band_we,
    input logic              div_we,
    input logic              commit_short,
    input logic              commit_long,
    input logic              commit_full
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        !rst_n |=> (band == '0 && divider == '0 && test == 3'b001 && cp_hi && rsb
                    && !os && rsa && !tune_en));

    // R3
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(band)) |-> $past(band_we));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(divider)) |-> $past(div_we));

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable({test, cp_hi, rsb, os})) |-> $past(commit_full));

    // R4
    long_rsa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(commit_long)) |-> !rsa);

    // R5
    short_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(commit_short)) |-> (!divider[DIV_W-1] && rsa));

    // R10
    tune_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$fell(tune_en));
endmodule

bind tuner_serial_loader tsl_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .band         (band_o),
    .divider      (divider_o),
    .test         (test_o),
    .cp_hi        (cp_hi_o),
    .rsb          (rsb_o),
    .os           (os_o),
    .rsa          (rsa_o),
    .tune_en      (tune_en_o),
    .band_we      (band_we),
    .div_we       (div_we),
    .commit_short (commit_short),
    .commit_long  (commit_long),
    .commit_full  (commit_full)
);

// File: tb/tuner_serial_loader_tb.sv
module tuner_serial_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sen = 1'b0;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [3:0]  band;
    logic [14:0] div;
    logic [2:0]  test;
    logic        cp_hi, rsb, os, rsa, tune_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    localparam int HALF = 6;

    always #2 clk = ~clk;

    tuner_serial_loader dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en_i  (sen),
        .bus_clk_i (sck),
        .bus_dat_i (sdi),
        .band_o    (band),
        .divider_o (div),
        .test_o    (test),
        .cp_hi_o   (cp_hi),
        .rsb_o     (rsb),
        .os_o      (os),
        .rsa_o     (rsa),
        .tune_en_o (tune_en)
    );

    // {len[60:56], data[55:26], band[25:22], div[21:7], test[6:4], cp[3], rsb[2], os[1], rsa[0]}
    localparam logic [60:0] VEC [10] = '{
        {5'd19, 30'({4'hA, 15'h4321}),              4'hA, 15'h4321, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd18, 30'({4'h5, 14'h2ABC}),              4'h5, 15'h2ABC, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1},
        {5'd27, 30'({4'hC, 15'h7FFF, 8'b1100_0100}), 4'hC, 15'h7FFF, 3'b110, 1'b0, 1'b0, 1'b1, 1'b1},
        {5'd19, 30'({4'h3, 15'h1234}),              4'h3, 15'h1234, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'd10, 30'({4'hF, 6'h3F}),                 4'hF, 15'h1234, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'd23, 30'({4'h6, 15'h0F0F, 4'hF}),        4'h6, 15'h0F0F, 3'b110, 1'b0, 1'b0, 1'b1, 1'b0},
        {5'd27, 30'({4'h1, 15'h0001, 8'b0011_1011}), 4'h1, 15'h0001, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd3,  30'(3'b111),                        4'h1, 15'h0001, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd30, 30'({4'h9, 15'h3333, 11'h7FF}),     4'h9, 15'h3333, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0},
        {5'd18, 30'({4'hE, 14'h3FFF}),              4'hE, 15'h3FFF, 3'b001, 1'b1, 1'b1, 1'b0, 1'b1}
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b);
        sdi = b;
        wait_cyc(HALF);
        sck = 1'b1;
        wait_cyc(HALF);
        sck = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic send_frame(input int len, input logic [29:0] data);
        sen = 1'b1;
        wait_cyc(HALF);
        for (int i = len - 1; i >= 0; i--) bus_bit(data[i]);
        sen = 1'b0;
        wait_cyc(12);
    endtask

    task automatic check_ctrl(input string req, input int t, input int c, input int b, input int o);
        check(req, "test", int'(test), t);
        check(req, "cp", int'(cp_hi), c);
        check(req, "rsb", int'(rsb), b);
        check(req, "os", int'(os), o);
    endtask

    function automatic string len_req(input int len);
        if (len == 19) return "R4";
        if (len == 18) return "R5";
        if (len == 27) return "R6";
        if (len < 18) return "R8";
        return "R9";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        // R1: defaults after reset
        check("R1", "band", int'(band), 0);
        check("R1", "div", int'(div), 0);
        check_ctrl("R1", 1, 1, 1, 0);
        check("R1", "rsa", int'(rsa), 1);
        check("R1", "tune_en", int'(tune_en), 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // Table walk; the state carries from each vector to the next
        for (int i = 0; i < 10; i++) begin
            send_frame(int'(VEC[i][60:56]), VEC[i][55:26]);
            check("R3", "band", int'(band), int'(VEC[i][25:22]));
            check(len_req(int'(VEC[i][60:56])), "div", int'(div), int'(VEC[i][21:7]));
            check("R7", "test", int'(test), int'(VEC[i][6:4]));
            check("R7", "cp", int'(cp_hi), int'(VEC[i][3]));
            check("R7", "rsb", int'(rsb), int'(VEC[i][2]));
            check("R7", "os", int'(os), int'(VEC[i][1]));
            check(len_req(int'(VEC[i][60:56])), "rsa", int'(rsa), int'(VEC[i][0]));
            check("R10", "tune_en", int'(tune_en), 1);
        end

        // R1 / R10: reset in mid-operation restores the defaults
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1", "band", int'(band), 0);
        check("R1", "div", int'(div), 0);
        check_ctrl("R1", 1, 1, 1, 0);
        check("R1", "rsa", int'(rsa), 1);
        check("R10", "tune_en", int'(tune_en), 0);

        // R2: clock pulses with enable low are ignored
        sdi = 1'b1;
        for (int k = 0; k < 6; k++) begin
            sck = 1'b1; wait_cyc(HALF);
            sck = 1'b0; wait_cyc(HALF);
        end
        check("R2", "band", int'(band), 0);
        check("R10", "tune_en", int'(tune_en), 0);
        send_frame(19, 30'({4'h2, 15'h1357}));
        check("R2", "band", int'(band), 2);
        check("R2", "div", int'(div), 15'h1357);
        check("R10", "tune_en", int'(tune_en), 1);

        // R3: band written on the 5th rising edge, not before; R8: 5-bit frame
        sen = 1'b1;
        wait_cyc(HALF);
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1); bus_bit(1'b1);
        check("R3", "band after 4 bits", int'(band), 2);
        bus_bit(1'b0);
        check("R3", "band after 5th rise", int'(band), 4'hB);
        sen = 1'b0;
        wait_cyc(12);
        check("R8", "div", int'(div), 15'h1357);
        check("R8", "rsa", int'(rsa), 0);

        // R6: 27-bit frame writes the divider before enable falls
        begin
            logic [26:0] f;
            f = {4'h7, 15'h2468, 8'b0101_1000};
            sen = 1'b1;
            wait_cyc(HALF);
            for (int i = 26; i >= 7; i--) bus_bit(f[i]);
            check("R6", "div before enable fall", int'(div), 15'h2468);
            check("R6", "test before enable fall", int'(test), 1);
            for (int i = 6; i >= 0; i--) bus_bit(f[i]);
            sen = 1'b0;
            wait_cyc(12);
            check_ctrl("R6", 2, 1, 1, 0);
            check("R7", "rsa", int'(rsa), 0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule